// File: doc/BRIEF.md
# Last-Level Miss Concurrency Monitor

This block watches the miss-handling table of the last-level cache and the request stream towards DRAM. It follows how many miss entries are in flight and keeps three saturating counters: DRAM accesses issued, cycles in which at least one miss entry is live (busy cycles), and the sum of live-entry counts taken over those busy cycles.

Software reads the raw counters and does the division itself. DRAM accesses divided by busy cycles gives the main-memory access rate per cycle. The occupancy sum divided by busy cycles gives the mean memory-level parallelism. If every miss has the same latency of m cycles, the access rate equals the parallelism divided by m. A synchronous clear zeroes the counters and the error flag so a new measurement window can start. The live occupancy is not cleared, because the misses it tracks are still in flight.

Top module: `miss_conc_monitor`

## Requirements
- R1: After reset, every output is zero: the three counters, `occ_o` and `err_o`.
- R2: Each cycle with `dram_issue_i` high raises `dram_cnt_o` by one, visible after the next rising edge.
- R3: Each cycle that starts with `occ_o` non-zero raises `busy_cyc_o` by one, visible after that cycle's rising edge. A cycle with `occ_o` at zero leaves it unchanged.
- R4: `alloc_i` alone raises `occ_o` by one. `free_i` alone lowers it by one. Both together leave it unchanged. The new value shows after the next rising edge.
- R5: `occ_o` never exceeds `MSHR_DEPTH`. When `occ_o` equals `MSHR_DEPTH`, an `alloc_i` without `free_i` is dropped and sets `err_o`.
- R6: When `occ_o` is zero, a `free_i` without `alloc_i` is dropped and sets `err_o`. `err_o` then stays high until a clear or a reset.
- R7: Each cycle that starts with `occ_o` non-zero adds that `occ_o` value to `occ_sum_o`, visible after that cycle's rising edge.
- R8: No counter wraps. On reaching all ones, a counter holds at all ones.
- R9: With `clr_i` high, the three counters and `err_o` read zero after the edge. This applies even if the same cycle holds events that would raise them. `occ_o` still follows R4 and R5.
- R10: Under traffic where each DRAM access allocates an entry in its issue cycle and frees it exactly m cycles later, `occ_sum_o` equals m times `dram_cnt_o` once all entries are freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of counters and error flag |
| dram_issue_i | input | 1 | One-cycle pulse per DRAM access issued |
| alloc_i | input | 1 | One-cycle pulse per miss entry allocated |
| free_i | input | 1 | One-cycle pulse per miss entry released |
| dram_cnt_o | output | CNT_W | DRAM accesses counted |
| busy_cyc_o | output | CNT_W | Cycles with at least one live miss entry |
| occ_sum_o | output | CNT_W+OCC_W | Sum of live-entry counts over busy cycles |
| occ_o | output | OCC_W | Live miss-entry count |
| err_o | output | 1 | Sticky flag for a dropped allocate or free |

## Verification
A wrong live count shows on `occ_o` one edge after the event that causes it. It also shows on `busy_cyc_o` and `occ_sum_o` in the next cycle, because both take it as input each cycle. An allocate or free that slips at the empty or full boundary shows at once as a change in `occ_o` without `err_o`, or as `err_o` without a change. It also throws off the fixed-latency identity for the rest of the window. A counter that wraps instead of saturating shows as a drop from all ones to a small value on the edge after it reaches its limit.

// File: rtl/mcm_pkg.sv
// Shared types for the miss concurrency monitor.
// Assumes: allocate and free are single-cycle pulses, at most one of each per cycle.
package mcm_pkg;

    typedef enum logic [1:0] {
        OCC_HOLD,
        OCC_UP,
        OCC_DOWN,
        OCC_REJECT
    } occ_op_e;

    // Maps one cycle's allocate/free pair to a change of the live count.
    function automatic occ_op_e occ_decode(input logic alloc,
                                           input logic free,
                                           input logic at_zero,
                                           input logic at_full);
        if (alloc == free) return OCC_HOLD;
        if (alloc)         return at_full ? OCC_REJECT : OCC_UP;
        return at_zero ? OCC_REJECT : OCC_DOWN;
    endfunction

endpackage

// File: rtl/mcm_occ_tracker.sv
// Live miss-entry count, bounded to [0, DEPTH].
// Assumes: one allocate and one free pulse at most per cycle. An event that would
// leave the bound is dropped and flagged on reject_o in the same cycle.
module mcm_occ_tracker
    import mcm_pkg::*;
#(
    parameter int DEPTH = 20,
    localparam int OW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_i,
    input  logic          free_i,
    output logic [OW-1:0] occ_o,
    output logic          busy_o,
    output logic          reject_o
);

    localparam logic [OW-1:0] FULL = OW'(DEPTH);

    logic [OW-1:0] occ_q;
    occ_op_e       op;

    // Classify this cycle's event pair against the current count.
    always_comb op = occ_decode(alloc_i, free_i, occ_q == '0, occ_q == FULL);

    // Apply the classified change to the live count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            case (op)
                OCC_UP:   occ_q <= occ_q + 1'b1;
                OCC_DOWN: occ_q <= occ_q - 1'b1;
                default:  occ_q <= occ_q;
            endcase
        end
    end

    assign occ_o    = occ_q;
    assign busy_o   = (occ_q != '0);
    assign reject_o = (op == OCC_REJECT);

    assert_occ_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= FULL);

    assert_full_alloc_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !free_i && occ_q == FULL) |=> occ_q == FULL);

    assert_empty_free_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (free_i && !alloc_i && occ_q == '0) |=> occ_q == '0);

    assert_pair_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && free_i) |=> $stable(occ_q));

endmodule

// File: rtl/mcm_sat_accum.sv
// Saturating accumulator: adds inc_i on each enabled cycle and holds at all ones.
// Assumes: IW <= W. A clear takes precedence over an enabled add.
module mcm_sat_accum #(
    parameter int W  = 48,
    parameter int IW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic [IW-1:0] inc_i,
    output logic [W-1:0]  val_o
);

    logic [W-1:0] val_q;
    logic [W:0]   sum;

    // Sum with one carry bit, used to detect the overflow that saturates.
    always_comb sum = {1'b0, val_q} + (W + 1)'(inc_i);

    // Register the cleared, saturated or held value.
    always_ff @(posedge clk) begin
        if (!rst_n)        val_q <= '0;
        else if (clr_i)    val_q <= '0;
        else if (en_i)     val_q <= sum[W] ? '1 : sum[W-1:0];
    end

    assign val_o = val_q;

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> val_q >= $past(val_q));

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> val_q == '0);

endmodule

// File: rtl/miss_conc_monitor.sv
// Last-level miss concurrency monitor.
// Counts DRAM accesses, cycles with a non-empty miss table, and the live-entry
// count summed over those cycles. Software divides the counters.
// Assumes: pulse inputs are synchronous to clk. Outputs are registered.
module miss_conc_monitor #(
    parameter int  MSHR_DEPTH = 20,
    parameter int  CNT_W      = 48,
    localparam int OCC_W      = $clog2(MSHR_DEPTH + 1),
    localparam int ACC_W      = CNT_W + OCC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             dram_issue_i,
    input  logic             alloc_i,
    input  logic             free_i,
    output logic [CNT_W-1:0] dram_cnt_o,
    output logic [CNT_W-1:0] busy_cyc_o,
    output logic [ACC_W-1:0] occ_sum_o,
    output logic [OCC_W-1:0] occ_o,
    output logic             err_o
);

    logic busy;
    logic reject;
    logic err_q;

    mcm_occ_tracker #(.DEPTH(MSHR_DEPTH)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_i  (alloc_i),
        .free_i   (free_i),
        .occ_o    (occ_o),
        .busy_o   (busy),
        .reject_o (reject)
    );

    mcm_sat_accum #(.W(CNT_W), .IW(1)) u_dram_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .en_i  (dram_issue_i),
        .inc_i (1'b1),
        .val_o (dram_cnt_o)
    );

    mcm_sat_accum #(.W(CNT_W), .IW(1)) u_busy_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .en_i  (busy),
        .inc_i (1'b1),
        .val_o (busy_cyc_o)
    );

    mcm_sat_accum #(.W(ACC_W), .IW(OCC_W)) u_occ_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .en_i  (busy),
        .inc_i (occ_o),
        .val_o (occ_sum_o)
    );

    // Sticky error flag for dropped events. A clear wins over a same-cycle reject.
    always_ff @(posedge clk) begin
        if (!rst_n)      err_q <= 1'b0;
        else if (clr_i)  err_q <= 1'b0;
        else if (reject) err_q <= 1'b1;
    end

    assign err_o = err_q;

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr_i) |=> err_q);

    assert_dram_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && dram_issue_i && dram_cnt_o != '1) |=> dram_cnt_o == $past(dram_cnt_o) + 1'b1);

    assert_idle_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && occ_o == '0) |=> $stable(busy_cyc_o) && $stable(occ_sum_o));

    assert_busy_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && occ_o != '0 && busy_cyc_o != '1) |=> busy_cyc_o == $past(busy_cyc_o) + 1'b1);

endmodule

// File: tb/miss_conc_monitor_bench.sv
// Scoreboard bench: the driver applies one cycle of stimulus, computes the expected
// outputs from the requirements and queues them. The monitor compares at the falling edge.
module miss_conc_monitor_bench;

    localparam int D   = 4;
    localparam int CW  = 6;
    localparam int OW  = $clog2(D + 1);
    localparam int AW  = CW + OW;
    localparam int CMAX = (1 << CW) - 1;
    localparam int AMAX = (1 << AW) - 1;

    typedef struct {
        int    dram;
        int    busy;
        int    acc;
        int    occ;
        int    err;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          dram_issue = 1'b0;
    logic          alloc = 1'b0;
    logic          free = 1'b0;
    logic [CW-1:0] dram_cnt;
    logic [CW-1:0] busy_cyc;
    logic [AW-1:0] occ_sum;
    logic [OW-1:0] occ;
    logic          err;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 0;
    exp_t exp_q[$];

    int m_dram = 0, m_busy = 0, m_acc = 0, m_occ = 0, m_err = 0;

    always #5 clk = ~clk;

    miss_conc_monitor #(.MSHR_DEPTH(D), .CNT_W(CW)) u_miss_conc_monitor (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (clr),
        .dram_issue_i (dram_issue),
        .alloc_i      (alloc),
        .free_i       (free),
        .dram_cnt_o   (dram_cnt),
        .busy_cyc_o   (busy_cyc),
        .occ_sum_o    (occ_sum),
        .occ_o        (occ),
        .err_o        (err)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, called at a rising edge time.
    task automatic step(input bit d, input bit a, input bit r, input bit c, input string tag);
        exp_t e;
        bit   bad;
        #1;
        dram_issue = d; alloc = a; free = r; clr = c;
        bad = 0;
        if (c) begin
            m_dram = 0; m_busy = 0; m_acc = 0;
        end else begin
            if (d) m_dram = (m_dram == CMAX) ? CMAX : m_dram + 1;
            if (m_occ != 0) begin
                m_busy = (m_busy == CMAX) ? CMAX : m_busy + 1;
                m_acc  = (m_acc + m_occ > AMAX) ? AMAX : m_acc + m_occ;
            end
        end
        if (a && !r) begin
            if (m_occ == D) bad = 1; else m_occ++;
        end else if (r && !a) begin
            if (m_occ == 0) bad = 1; else m_occ--;
        end
        if (c) m_err = 0;
        else if (bad) m_err = 1;
        e.dram = m_dram; e.busy = m_busy; e.acc = m_acc;
        e.occ = m_occ; e.err = m_err; e.tag = tag;
        @(posedge clk);
        exp_q.push_back(e);
    endtask

    // Monitor: pop one expected item per cycle and compare.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                bit   ok;
                e = exp_q.pop_front();
                n_chk++;
                ok = (int'(dram_cnt) == e.dram) && (int'(busy_cyc) == e.busy) &&
                     (int'(occ_sum) == e.acc) && (int'(occ) == e.occ) && (int'(err) == e.err);
                if (!ok) begin
                    n_err++;
                    $display("FAIL %s dram=%0d/%0d busy=%0d/%0d sum=%0d/%0d occ=%0d/%0d err=%0d/%0d (actual/expected)",
                             e.tag, dram_cnt, e.dram, busy_cyc, e.busy, occ_sum, e.acc,
                             occ, e.occ, err, e.err);
                end
            end
        end
    end

    function automatic bit fl_start(input int k);
        return (k == 0) || (k == 1) || (k == 2) || (k == 5) || (k == 6) || (k == 10);
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "dram_cnt", int'(dram_cnt), 0);
        chk("R1", "busy_cyc", int'(busy_cyc), 0);
        chk("R1", "occ_sum", int'(occ_sum), 0);
        chk("R1", "occ", int'(occ), 0);
        chk("R1", "err", int'(err), 0);
        @(posedge clk);

        step(1, 0, 0, 0, "R2");
        step(1, 0, 0, 0, "R2");
        step(0, 0, 0, 0, "R2");
        step(0, 1, 0, 0, "R4");
        step(0, 1, 0, 0, "R4");
        step(0, 1, 1, 0, "R4");
        step(0, 0, 1, 0, "R4");
        step(0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, "R7");
        step(0, 1, 0, 0, "R5");
        step(0, 1, 0, 0, "R5");
        step(0, 1, 0, 0, "R5");
        step(0, 1, 0, 0, "R5");
        step(0, 1, 1, 0, "R5");
        step(1, 0, 0, 1, "R9");
        step(0, 0, 0, 0, "R9");
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, "R6");
        step(0, 0, 1, 0, "R6");
        step(0, 0, 0, 0, "R6");
        step(0, 1, 1, 0, "R6");
        step(0, 0, 0, 0, "R3");

        // R10: fixed latency of 3 cycles, overlapping accesses
        step(0, 0, 0, 1, "R10");
        for (int k = 0; k < 15; k++)
            step(fl_start(k), fl_start(k), (k >= 3) && fl_start(k - 3), 0, "R10");
        @(negedge clk);
        chk("R10", "sum_vs_3xdram", int'(occ_sum), 3 * int'(dram_cnt));
        chk("R10", "dram_cnt", int'(dram_cnt), 6);
        @(posedge clk);

        // R8: saturation of every counter
        step(0, 0, 0, 1, "R8");
        for (int i = 0; i < 70; i++) step(1, 0, 0, 0, "R8");
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0, "R8");
        for (int i = 0; i < 130; i++) step(0, 0, 0, 0, "R8");
        @(negedge clk);
        chk("R8", "dram_cnt", int'(dram_cnt), CMAX);
        chk("R8", "busy_cyc", int'(busy_cyc), CMAX);
        chk("R8", "occ_sum", int'(occ_sum), AMAX);

        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule